// File: doc/BRIEF.md
# Two-Row Matrix Product Sequencer

This block sets the order in which operands are fetched and results are written when two square matrices of 8-bit elements are multiplied. Two independent memories each feed one fetch stream. Stream A serves odd-numbered rows and columns, and stream B serves even-numbered ones. Rows are processed two at a time. For each pair, the first row is loaded into dot-product lane 1 and the second into lane 2. Every column is then streamed once, and each column vector is applied to both lanes together.

The arithmetic and the FIFOs sit outside the block. The sequencer issues one request per full vector on each stream, but only when that stream's FIFO reports room. It accepts one pair of lane sums per column and emits the two sums as tagged 32-bit words, lane 1 first. When the final element has been accepted downstream, it pulses `done`.

Top module: `rpmm_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `wr_valid`, `sa_req` and `sb_req` are all low. No fetch is requested while idle, even if both room inputs are high.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle and restarts the sequence at row 1, column 1. A `start` pulse seen while busy has no effect on the fetch or result sequence.
- R3: A stream raises its request strobe only in a cycle in which its own room input is high.
- R4: The request kind is 0 for a row vector and 1 for a column vector. The index is 1-based. Stream A only ever requests odd indices and stream B only even indices.
- R5: For each row pair (i, i+1), the global request order is: row i on A, row i+1 on B, column 1 on A, column 2 on B, and so on, alternating, up to column N on B. The row index then advances by 2 until all N rows are done. At most one request is issued per cycle.
- R6: A lane-sum pair is taken through the `pr_valid`/`pr_ready` handshake. `pr_ready` is high only while busy and while no earlier pair is still waiting to be written.
- R7: Result words leave in the order (1,1), (2,1), (1,2), (2,2), …, (N-1,N), (N,N). For each column, the lane 1 word (odd row) comes before the lane 2 word (even row). `wr_row` and `wr_col` carry the 1-based coordinates of the word.
- R8: `wr_data` is the lane sum zero-extended to 32 bits. While `wr_valid` is high and `wr_ready` is low, `wr_data`, `wr_row` and `wr_col` hold steady.
- R9: `done` is high for exactly one cycle: the cycle after element (N,N) is accepted. `busy` is low from that same cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product when idle |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion pulse |
| sa_room | input | 1 | Stream A FIFO can take a full vector |
| sa_req | output | 1 | Stream A fetch strobe |
| sa_kind | output | 1 | Stream A kind: 0 row, 1 column |
| sa_idx | output | IDX_W | Stream A 1-based vector index |
| sb_room | input | 1 | Stream B FIFO can take a full vector |
| sb_req | output | 1 | Stream B fetch strobe |
| sb_kind | output | 1 | Stream B kind: 0 row, 1 column |
| sb_idx | output | IDX_W | Stream B 1-based vector index |
| pr_valid | input | 1 | Lane-sum pair offered |
| pr_ready | output | 1 | Lane-sum pair taken |
| pr_sum1 | input | ACC_W | Lane 1 (odd row) dot product |
| pr_sum2 | input | ACC_W | Lane 2 (even row) dot product |
| wr_valid | output | 1 | Result word offered |
| wr_ready | input | 1 | Result word taken downstream |
| wr_data | output | 32 | Result word |
| wr_row | output | IDX_W | Row of the result word |
| wr_col | output | IDX_W | Column of the result word |

## Verification
The hardest situation to reach is a stream whose turn has come while its own FIFO is full. The other stream has room but must not overtake, and at the same moment the result side is stalled with a word held. The bench reaches this by driving both room inputs and `wr_ready` from an LFSR during a full product on a 4x4 configuration. It also drops a stray `start` in the middle of that run. It then runs a second product with every input open, so that the sequence restart and the back-to-back request alternation are both exercised.

// File: rtl/rpmm_pkg.sv
package rpmm_pkg;

    localparam int WORD_W  = 32;
    localparam int NSTREAM = 2;

    typedef enum logic [1:0] {
        SF_IDLE,
        SF_ROW,
        SF_COL
    } sfetch_t;

    typedef enum logic [1:0] {
        RO_EMPTY,
        RO_LANE1,
        RO_LANE2
    } rord_t;

    typedef enum logic {
        FK_ROW = 1'b0,
        FK_COL = 1'b1
    } fkind_t;

    typedef struct packed {
        logic   req;
        fkind_t kind;
    } fstrobe_t;

    function automatic int acc_width(input int n, input int ew);
        return 2 * ew + $clog2(n);
    endfunction

endpackage

// File: rtl/rpmm_fetch_stream.sv
module rpmm_fetch_stream
    import rpmm_pkg::*;
#(
    parameter int N     = 128,
    parameter int SID   = 0,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             grant,
    input  logic             room,
    output fstrobe_t         strobe,
    output logic [IDX_W-1:0] idx
);
    localparam int HALF  = N / 2;
    localparam int PAIRS = N / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    sfetch_t          st_q;
    logic [CNT_W-1:0] pair_q;
    logic [CNT_W-1:0] col_q;
    logic             fire;
    logic [CNT_W-1:0] sel;

    assign fire = (st_q != SF_IDLE) && grant && room;

    always_comb begin
        sel         = (st_q == SF_COL) ? col_q : pair_q;
        strobe.req  = fire;
        strobe.kind = (st_q == SF_COL) ? FK_COL : FK_ROW;
        idx         = IDX_W'({sel, 1'b0}) + IDX_W'(SID + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SF_IDLE;
            pair_q <= '0;
            col_q  <= '0;
        end else if (launch) begin
            st_q   <= SF_ROW;
            pair_q <= '0;
            col_q  <= '0;
        end else if (fire) begin
            case (st_q)
                SF_ROW: begin
                    st_q  <= SF_COL;
                    col_q <= '0;
                end
                SF_COL: begin
                    if (col_q == CNT_W'(HALF - 1)) begin
                        col_q <= '0;
                        if (pair_q == CNT_W'(PAIRS - 1)) begin
                            st_q <= SF_IDLE;
                        end else begin
                            pair_q <= pair_q + 1'b1;
                            st_q   <= SF_ROW;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: st_q <= SF_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rpmm_result_order.sv
module rpmm_result_order
    import rpmm_pkg::*;
#(
    parameter int N     = 128,
    parameter int ACC_W = 23,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              busy,
    input  logic              pr_valid,
    output logic              pr_ready,
    input  logic [ACC_W-1:0]  pr_sum1,
    input  logic [ACC_W-1:0]  pr_sum2,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_data,
    output logic [IDX_W-1:0]  wr_row,
    output logic [IDX_W-1:0]  wr_col,
    output logic              last_accept
);
    rord_t            st_q;
    logic [ACC_W-1:0] s1_q;
    logic [ACC_W-1:0] s2_q;
    logic [IDX_W-1:0] row_q;
    logic [IDX_W-1:0] col_q;
    logic             at_last;

    always_comb begin
        pr_ready    = busy && (st_q == RO_EMPTY);
        wr_valid    = (st_q != RO_EMPTY);
        wr_data     = WORD_W'((st_q == RO_LANE2) ? s2_q : s1_q);
        wr_row      = (st_q == RO_LANE2) ? row_q + 1'b1 : row_q;
        wr_col      = col_q;
        at_last     = (row_q == IDX_W'(N - 1)) && (col_q == IDX_W'(N));
        last_accept = (st_q == RO_LANE2) && wr_ready && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RO_EMPTY;
            s1_q  <= '0;
            s2_q  <= '0;
            row_q <= IDX_W'(1);
            col_q <= IDX_W'(1);
        end else if (launch) begin
            st_q  <= RO_EMPTY;
            row_q <= IDX_W'(1);
            col_q <= IDX_W'(1);
        end else begin
            case (st_q)
                RO_EMPTY: begin
                    if (pr_valid && pr_ready) begin
                        s1_q <= pr_sum1;
                        s2_q <= pr_sum2;
                        st_q <= RO_LANE1;
                    end
                end
                RO_LANE1: begin
                    if (wr_ready) st_q <= RO_LANE2;
                end
                RO_LANE2: begin
                    if (wr_ready) begin
                        st_q <= RO_EMPTY;
                        if (!at_last) begin
                            if (col_q == IDX_W'(N)) begin
                                col_q <= IDX_W'(1);
                                row_q <= row_q + IDX_W'(2);
                            end else begin
                                col_q <= col_q + 1'b1;
                            end
                        end
                    end
                end
                default: st_q <= RO_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/rpmm_sequencer.sv
module rpmm_sequencer
    import rpmm_pkg::*;
#(
    parameter int N      = 128,
    parameter int ELEM_W = 8,
    parameter int ACC_W  = acc_width(N, ELEM_W),
    parameter int IDX_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic              sa_room,
    output logic              sa_req,
    output logic              sa_kind,
    output logic [IDX_W-1:0]  sa_idx,
    input  logic              sb_room,
    output logic              sb_req,
    output logic              sb_kind,
    output logic [IDX_W-1:0]  sb_idx,
    input  logic              pr_valid,
    output logic              pr_ready,
    input  logic [ACC_W-1:0]  pr_sum1,
    input  logic [ACC_W-1:0]  pr_sum2,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_data,
    output logic [IDX_W-1:0]  wr_row,
    output logic [IDX_W-1:0]  wr_col
);
    logic             busy_q;
    logic             done_q;
    logic             turn_q;
    logic             launch;
    logic             last_accept;
    logic [NSTREAM-1:0] room_v;
    logic [NSTREAM-1:0] req_v;
    fstrobe_t         strobe_v [NSTREAM];
    logic [IDX_W-1:0] idx_v    [NSTREAM];

    assign launch = start && !busy_q;
    assign room_v = {sb_room, sa_room};

    for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
        rpmm_fetch_stream #(
            .N     (N),
            .SID   (g),
            .IDX_W (IDX_W)
        ) u_stream (
            .clk    (clk),
            .rst    (rst),
            .launch (launch),
            .grant  (turn_q == 1'(g)),
            .room   (room_v[g]),
            .strobe (strobe_v[g]),
            .idx    (idx_v[g])
        );
        assign req_v[g] = strobe_v[g].req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            turn_q <= 1'b0;
        end else begin
            done_q <= last_accept;
            if (launch) begin
                busy_q <= 1'b1;
                turn_q <= 1'b0;
            end else begin
                if (last_accept) busy_q <= 1'b0;
                if (|req_v) turn_q <= ~turn_q;
            end
        end
    end

    rpmm_result_order #(
        .N     (N),
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_order (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .busy        (busy_q),
        .pr_valid    (pr_valid),
        .pr_ready    (pr_ready),
        .pr_sum1     (pr_sum1),
        .pr_sum2     (pr_sum2),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_data     (wr_data),
        .wr_row      (wr_row),
        .wr_col      (wr_col),
        .last_accept (last_accept)
    );

    assign busy    = busy_q;
    assign done    = done_q;
    assign sa_req  = req_v[0];
    assign sa_kind = strobe_v[0].kind;
    assign sa_idx  = idx_v[0];
    assign sb_req  = req_v[1];
    assign sb_kind = strobe_v[1].kind;
    assign sb_idx  = idx_v[1];

endmodule

// File: rtl/rpmm_sequencer_chk.sv
module rpmm_sequencer_chk #(
    parameter int N     = 128,
    parameter int ACC_W = 23,
    parameter int IDX_W = $clog2(N + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             sa_room,
    input logic             sa_req,
    input logic             sa_kind,
    input logic [IDX_W-1:0] sa_idx,
    input logic             sb_room,
    input logic             sb_req,
    input logic             sb_kind,
    input logic [IDX_W-1:0] sb_idx,
    input logic             pr_valid,
    input logic             pr_ready,
    input logic [ACC_W-1:0] pr_sum1,
    input logic [ACC_W-1:0] pr_sum2,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [31:0]      wr_data,
    input logic [IDX_W-1:0] wr_row,
    input logic [IDX_W-1:0] wr_col
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sa_req && !sb_req && !wr_valid));                          // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);                                            // R2
    AST_A_ROOM: assert property (@(posedge clk) disable iff (rst)
        sa_req |-> sa_room);                                                   // R3
    AST_B_ROOM: assert property (@(posedge clk) disable iff (rst)
        sb_req |-> sb_room);                                                   // R3
    AST_A_ODD: assert property (@(posedge clk) disable iff (rst)
        sa_req |-> sa_idx[0]);                                                 // R4
    AST_B_EVEN: assert property (@(posedge clk) disable iff (rst)
        sb_req |-> !sb_idx[0]);                                                // R4
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        !(sa_req && sb_req));                                                  // R5
    AST_PAIR_GATE: assert property (@(posedge clk) disable iff (rst)
        pr_ready |-> (busy && !wr_valid));                                     // R6
    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_row[0]) |=>
            (wr_valid && wr_row == $past(wr_row) + 1'b1 && $stable(wr_col))); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_data) && $stable(wr_row) && $stable(wr_col))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                       // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                       // R9
endmodule

bind rpmm_sequencer rpmm_sequencer_chk #(
    .N     (N),
    .ACC_W (ACC_W),
    .IDX_W (IDX_W)
) u_chk (.*);

// File: tb/tb_rpmm_sequencer.sv
module tb_rpmm_sequencer;
    localparam int N     = 4;
    localparam int EW    = 8;
    localparam int ACC_W = 2 * EW + $clog2(N);
    localparam int IDX_W = $clog2(N + 1);
    localparam int NFETCH = (N / 2) * (N + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done;
    logic sa_room = 1'b0, sb_room = 1'b0;
    logic sa_req, sa_kind, sb_req, sb_kind;
    logic [IDX_W-1:0] sa_idx, sb_idx;
    logic pr_valid = 1'b0;
    logic pr_ready;
    logic [ACC_W-1:0] pr_sum1 = '0, pr_sum2 = '0;
    logic wr_valid;
    logic wr_ready = 1'b0;
    logic [31:0] wr_data;
    logic [IDX_W-1:0] wr_row, wr_col;

    int n_tests = 0;
    int n_fail  = 0;
    int fk = 0;
    int rk = 0;
    int run_id = 0;
    bit pend_done = 1'b0;
    int done_seen = 0;
    bit rnd_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    rpmm_sequencer #(.N(N), .ELEM_W(EW)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int val(input int r, input int c);
        return (r * 37 + c * 11 + run_id * 5) & ((1 << ACC_W) - 1);
    endfunction

    // random room and ready drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rnd_mode) begin
                sa_room  = lfsr[0] | lfsr[3];
                sb_room  = lfsr[1] & lfsr[5] | lfsr[7];
                wr_ready = lfsr[2] | lfsr[9];
            end
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (pend_done) begin
                    chk(done === 1'b1, "R9", "done after last accept", done, 1);
                    chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
                    done_seen++;
                    pend_done = 1'b0;
                end else if (done) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end
                if (sa_req && sb_req) chk(1'b0, "R5", "two requests in one cycle", 2, 1);
                for (int s = 0; s < 2; s++) begin
                    bit r; bit k; int ix; bit rm;
                    r  = (s == 0) ? sa_req : sb_req;
                    k  = (s == 0) ? sa_kind : sb_kind;
                    ix = (s == 0) ? int'(sa_idx) : int'(sb_idx);
                    rm = (s == 0) ? sa_room : sb_room;
                    if (r) begin
                        int p, q, es, ek, ei;
                        p = fk / (N + 2);
                        q = fk % (N + 2);
                        if (q < 2) begin
                            es = q; ek = 0; ei = 2 * p + 1 + q;
                        end else begin
                            ei = q - 1; ek = 1; es = (ei % 2 == 1) ? 0 : 1;
                        end
                        chk(rm === 1'b1, "R3", "request without room", rm, 1);
                        chk(s == es, "R5", "request stream", s, es);
                        chk(int'(k) == ek, "R4", "request kind", k, ek);
                        chk(ix == ei, "R4", "request index", ix, ei);
                        fk++;
                    end
                end
                if (wr_valid && wr_ready) begin
                    int p, rem, ec, er;
                    p   = rk / (2 * N);
                    rem = rk % (2 * N);
                    ec  = rem / 2 + 1;
                    er  = 2 * p + 1 + rem % 2;
                    chk(int'(wr_row) == er, "R7", "result row", wr_row, er);
                    chk(int'(wr_col) == ec, "R7", "result col", wr_col, ec);
                    chk(wr_data == 32'(val(er, ec)), "R8", "result data", wr_data, val(er, ec));
                    if (rk == N * N - 1) pend_done = 1'b1;
                    rk++;
                end
            end
        end
    end

    task automatic send_pairs();
        for (int p = 0; p < N / 2; p++) begin
            for (int c = 1; c <= N; c++) begin
                @(posedge clk);
                #1;
                pr_valid = 1'b1;
                pr_sum1  = ACC_W'(val(2 * p + 1, c));
                pr_sum2  = ACC_W'(val(2 * p + 2, c));
                do @(negedge clk); while (!pr_ready);
                @(posedge clk);
                #1;
                pr_valid = 1'b0;
            end
        end
    endtask

    task automatic pulse_start();
        @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic run_product(input bit noisy);
        fk = 0;
        rk = 0;
        pulse_start();
        @(negedge clk);
        chk(busy === 1'b1, "R2", "busy after start", busy, 1);
        fork
            send_pairs();
            if (noisy) begin
                repeat (9) @(posedge clk);
                pulse_start();
                @(negedge clk);
                chk(busy === 1'b1, "R2", "busy kept on stray start", busy, 1);
            end
        join
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(fk == NFETCH, "R5", "fetch count", fk, NFETCH);
        chk(rk == N * N, "R7", "result count", rk, N * N);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst = 1'b0;
                sa_room = 1'b1;
                sb_room = 1'b1;
                wr_ready = 1'b1;
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    chk(!busy && !done && !wr_valid, "R1", "idle outputs", busy, 0);
                    chk(!sa_req && !sb_req, "R1", "no request while idle", sa_req | sb_req, 0);
                end
                run_id = 1;
                rnd_mode = 1'b1;
                run_product(1'b1);
                rnd_mode = 1'b0;
                @(posedge clk);
                #1;
                sa_room = 1'b1;
                sb_room = 1'b1;
                wr_ready = 1'b1;
                run_id = 2;
                run_product(1'b0);
                chk(done_seen == 2, "R9", "done pulse count", done_seen, 2);
                repeat (4) begin
                    @(negedge clk);
                    chk(!sa_req && !sb_req && !wr_valid, "R1", "quiet after done", sa_req | sb_req, 0);
                end
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "R1", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule